// File: doc/BRIEF.md
# USB High-Speed Link State Detector

This block follows the state of a USB 2.0 link from digitized line indications and raises two flags. The first says a device is attached. The second says the link runs at high speed, and it also drives the enable of the high-speed signal compensation path. Analog sensing sits outside the block. It hands the block a two-bit line state, a pull-up-detect flag, a squelch flag, a compliance-fixture-detect flag and a test-packet-seen flag. A one-cycle microsecond tick serves as the time base for every duration the block measures. Because of that tick, the block can run from any clock.

A low- or full-speed attach only marks the link as connected. High speed is declared in two ways. The first is a bus reset (SE0) followed by one chirp J and then one chirp K, each of bounded length, and then squelch. The second is a compliance fixture seen from the unconnected state, followed by a test packet. A chirp of the wrong length sends the block back to waiting for a bus reset. So does a chirp in the wrong order or an extra chirp.

An active-low enable pin puts the block into shutdown, but only after it has been low for a minimum time, so short glitches are ignored. A configuration hold input keeps the state machine idle. All inputs except the tick pass through a parameterized synchronizer.

Top module: `ls_hs_link_det`

## Requirements
- R1: From the unconnected state, `pu_det` = 1 raises `conn_det` in the next cycle. In any pull-up-attached state, `pu_det` = 0 returns the block to unconnected, with `conn_det` and `hs_active` both 0 in the next cycle.
- R2: A low/full-speed attach (pull-up present, no bus reset) gives `conn_det` = 1 with `hs_active` = 0 and `comp_en` = 0.
- R3: A bus reset is recognised only when `line_st` = 2'b00 (SE0) is held for SE0_RST_US ticks while attached. Chirps seen without a preceding recognised reset never lead to high speed.
- R4: After a bus reset, a chirp J (`line_st` = 2'b01) followed by a chirp K (`line_st` = 2'b10) is accepted if each lasts between CHIRP_MIN_US and CHIRP_MAX_US ticks, both limits included. The next `squelch` = 1 then sets `hs_active` = 1.
- R5: Any of the following aborts the handshake and returns the block to waiting for a bus reset, with `conn_det` = 1 and `hs_active` = 0:
  - a chirp shorter than CHIRP_MIN_US ticks;
  - a chirp that reaches CHIRP_MAX_US + 1 ticks;
  - a chirp K that comes first;
  - a further J or K before squelch.
- R6: `fixture_det` = 1 in the unconnected state, followed by `tpkt_seen` = 1, sets `hs_active` = 1 and `conn_det` = 1. Dropping `fixture_det` clears both. `tpkt_seen` has no effect without a fixture.
- R7: `pin_rst_n` held low for RST_MIN_US ticks forces shutdown, with both flags and `comp_en` at 0. A shorter low pulse leaves the state unchanged. On release, the block restarts from unconnected.
- R8: While `cfg_hold` = 1 the state machine is idle in the unconnected state, with both flags 0. After release it resumes normal detection.
- R9: `comp_en` equals `hs_active` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low flop reset |
| pin_rst_n | input | 1 | Active-low enable pin, glitch-filtered by duration |
| cfg_hold | input | 1 | Holds the state machine idle while 1 |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| line_st | input | 2 | Line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| pu_det | input | 1 | Pull-up resistor sensed on a data line |
| squelch | input | 1 | Differential signal below squelch level |
| fixture_det | input | 1 | Compliance test fixture sensed |
| tpkt_seen | input | 1 | Test-packet pattern observed |
| conn_det | output | 1 | Connection detected flag |
| hs_active | output | 1 | High-speed mode flag |
| comp_en | output | 1 | Signal compensation enable |

## Verification
The bench builds the block with SYNC_STAGES = 0, so every input takes effect at the next clock edge and the reference model can stay cycle-exact. It keeps the default limits: 18 and 128 ticks for chirps, 20 for the enable filter and 3 for the SE0 reset. It shortens the microsecond to four clocks. That puts both chirp boundaries on each side (17, 18, 128, 129 ticks) and the 20-tick shutdown filter within a few hundred cycles. Every cycle is compared against the model in addition to the directed checks.

// File: rtl/ls_link_pkg.sv
package ls_link_pkg;

   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_J   = 2'b01,
      LN_K   = 2'b10,
      LN_SE1 = 2'b11
   } line_e;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_UNCONN,
      ST_ATTACHED,
      ST_BUS_RST,
      ST_CHIRP_J,
      ST_CHIRP_K,
      ST_HS_PEND,
      ST_HS_RUN,
      ST_FIX_WAIT,
      ST_FIX_RUN
   } lnk_st_e;

   // states entered through a sensed pull-up
   function automatic logic st_pullup(lnk_st_e s);
      return (s == ST_ATTACHED) || (s == ST_BUS_RST) || (s == ST_CHIRP_J) ||
             (s == ST_CHIRP_K)  || (s == ST_HS_PEND) || (s == ST_HS_RUN);
   endfunction

   function automatic logic st_connected(lnk_st_e s);
      return st_pullup(s) || (s == ST_FIX_RUN);
   endfunction

   function automatic logic st_highspeed(lnk_st_e s);
      return (s == ST_HS_RUN) || (s == ST_FIX_RUN);
   endfunction

endpackage

// File: rtl/ls_in_sync.sv
module ls_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (W >= 1 && STAGES >= 0 && STAGES <= 4)
         else $fatal(1, "ls_in_sync: bad W or STAGES");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stg
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg[i] <= '0;
                  else        stg[i] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg[i] <= '0;
                  else        stg[i] <= stg[i-1];
               end
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ls_rst_filter.sv
module ls_rst_filter #(
   parameter int MIN_US = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic us_tick,
   output logic shut
);

   localparam int           CW  = $clog2(MIN_US + 1);
   localparam logic [CW-1:0] LIM = CW'(MIN_US);

   initial begin
      assert (MIN_US >= 1) else $fatal(1, "ls_rst_filter: MIN_US must be >= 1");
   end

   logic [CW-1:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   low_q <= '0;
      else if (pin_n)               low_q <= '0;
      else if (us_tick && low_q != LIM) low_q <= low_q + 1'b1;
   end

   assign shut = (low_q == LIM);

   // R7: a released pin ends shutdown at once, so a short pulse never shuts
   p_release_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_n |=> !shut);
   p_shut_needs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shut) |-> !$past(pin_n));

endmodule

// File: rtl/ls_dur_timer.sv
module ls_dur_timer #(
   parameter int SAT = 128
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       us_tick,
   output logic [$clog2(SAT+1)-1:0]   cnt
);

   localparam int           CW    = $clog2(SAT + 1);
   localparam logic [CW-1:0] SAT_V = CW'(SAT);

   initial begin
      assert (SAT >= 1) else $fatal(1, "ls_dur_timer: SAT must be >= 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (us_tick && cnt != SAT_V) cnt <= cnt + 1'b1;
   end

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !us_tick) |=> $stable(cnt));

endmodule

// File: rtl/ls_hs_link_det.sv
module ls_hs_link_det
   import ls_link_pkg::*;
#(
   parameter int CHIRP_MIN_US = 18,
   parameter int CHIRP_MAX_US = 128,
   parameter int SE0_RST_US   = 3,
   parameter int RST_MIN_US   = 20,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_rst_n,
   input  logic       cfg_hold,
   input  logic       us_tick,
   input  logic [1:0] line_st,
   input  logic       pu_det,
   input  logic       squelch,
   input  logic       fixture_det,
   input  logic       tpkt_seen,
   output logic       conn_det,
   output logic       hs_active,
   output logic       comp_en
);

   localparam int           CNT_W  = $clog2(CHIRP_MAX_US + 1);
   localparam int           IN_W   = 8;
   localparam logic [CNT_W-1:0] SE0_LAST = CNT_W'(SE0_RST_US - 1);
   localparam logic [CNT_W-1:0] CH_MAX_V = CNT_W'(CHIRP_MAX_US);
   localparam logic [CNT_W-1:0] CH_MIN_V = CNT_W'(CHIRP_MIN_US);

   initial begin
      assert (CHIRP_MIN_US >= 1 && CHIRP_MIN_US <= CHIRP_MAX_US)
         else $fatal(1, "ls_hs_link_det: chirp limits out of order");
      assert (SE0_RST_US >= 1 && SE0_RST_US <= CHIRP_MAX_US)
         else $fatal(1, "ls_hs_link_det: SE0_RST_US out of range");
   end

   // ---------------- input synchronisation ----------------
   logic [IN_W-1:0] raw_in, syn_in;
   logic            pin_s, hold_s, pu_s, sq_s, fix_s, tp_s;
   line_e           ln_s;

   assign raw_in = {pin_rst_n, cfg_hold, line_st, pu_det, squelch, fixture_det, tpkt_seen};

   ls_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign pin_s  = syn_in[7];
   assign hold_s = syn_in[6];
   assign ln_s   = line_e'(syn_in[5:4]);
   assign pu_s   = syn_in[3];
   assign sq_s   = syn_in[2];
   assign fix_s  = syn_in[1];
   assign tp_s   = syn_in[0];

   // ---------------- enable pin filter ----------------
   logic shut;

   ls_rst_filter #(.MIN_US(RST_MIN_US)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (pin_s),
      .us_tick (us_tick),
      .shut    (shut)
   );

   // ---------------- duration timer ----------------
   lnk_st_e          st_q, st_d;
   logic [CNT_W-1:0] dur;
   logic             dur_clr;
   logic             in_win, at_max;

   ls_dur_timer #(.SAT(CHIRP_MAX_US)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (dur_clr),
      .us_tick (us_tick),
      .cnt     (dur)
   );

   assign in_win  = (dur >= CH_MIN_V) && (dur <= CH_MAX_V);
   assign at_max  = us_tick && (dur == CH_MAX_V);
   assign dur_clr = (st_d != st_q) || ((st_q == ST_ATTACHED) && (ln_s != LN_SE0));

   // ---------------- link state machine ----------------
   always_comb begin
      st_d = st_q;
      if (shut) begin
         st_d = ST_OFF;
      end else if (st_q == ST_OFF || hold_s) begin
         st_d = ST_UNCONN;
      end else if (st_pullup(st_q) && !pu_s) begin
         st_d = ST_UNCONN;
      end else begin
         case (st_q)
            ST_UNCONN: begin
               if (pu_s)       st_d = ST_ATTACHED;
               else if (fix_s) st_d = ST_FIX_WAIT;
            end
            ST_ATTACHED: begin
               if (ln_s == LN_SE0 && us_tick && dur == SE0_LAST) st_d = ST_BUS_RST;
            end
            ST_BUS_RST: begin
               if (ln_s == LN_J)      st_d = ST_CHIRP_J;
               else if (ln_s == LN_K) st_d = ST_ATTACHED;
            end
            ST_CHIRP_J: begin
               if (ln_s != LN_J)  st_d = (ln_s == LN_K && in_win) ? ST_CHIRP_K : ST_ATTACHED;
               else if (at_max)   st_d = ST_ATTACHED;
            end
            ST_CHIRP_K: begin
               if (ln_s != LN_K)  st_d = in_win ? ST_HS_PEND : ST_ATTACHED;
               else if (at_max)   st_d = ST_ATTACHED;
            end
            ST_HS_PEND: begin
               if (sq_s)                                st_d = ST_HS_RUN;
               else if (ln_s == LN_J || ln_s == LN_K)   st_d = ST_ATTACHED;
            end
            ST_FIX_WAIT: begin
               if (!fix_s)     st_d = ST_UNCONN;
               else if (tp_s)  st_d = ST_FIX_RUN;
            end
            ST_FIX_RUN: begin
               if (!fix_s)     st_d = ST_UNCONN;
            end
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= st_d;
   end

   assign conn_det  = st_connected(st_q);
   assign hs_active = st_highspeed(st_q);
   assign comp_en   = hs_active;

   // ---------------- assertions ----------------
   p_disc_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_pullup(st_q) && !pu_s) |=> (!conn_det && !hs_active));

   p_hs_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_active) |-> ($past(sq_s) || $past(tp_s)));

   p_chirp_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HS_PEND && $past(st_q) == ST_CHIRP_K) |->
         ($past(dur) >= CH_MIN_V && $past(dur) <= CH_MAX_V));

   p_no_hs_from_attach_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ATTACHED) |=> !hs_active);

   p_shutdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shut |=> (!conn_det && !hs_active && !comp_en));

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && !shut) |=> (!conn_det && !hs_active));

endmodule

// File: tb/tb_ls_hs_link_det.sv
`timescale 1ns/1ps
module tb_ls_hs_link_det;

   localparam int MINC   = 18;
   localparam int MAXC   = 128;
   localparam int SE0R   = 3;
   localparam int RSTMIN = 20;

   logic       clk = 1'b0;
   logic       rst_n, pin_n, hold, tick, pu, sq, fix, tp;
   logic [1:0] line;
   logic       conn, hs, comp;

   int    nchk = 0;
   int    nbad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";
   int    ph = 0;

   always #2.5 clk = ~clk;

   ls_hs_link_det #(
      .CHIRP_MIN_US (MINC),
      .CHIRP_MAX_US (MAXC),
      .SE0_RST_US   (SE0R),
      .RST_MIN_US   (RSTMIN),
      .SYNC_STAGES  (0)
   ) dut (
      .clk (clk), .rst_n (rst_n), .pin_rst_n (pin_n), .cfg_hold (hold),
      .us_tick (tick), .line_st (line), .pu_det (pu), .squelch (sq),
      .fixture_det (fix), .tpkt_seen (tp),
      .conn_det (conn), .hs_active (hs), .comp_en (comp)
   );

   // microsecond = 4 clocks
   initial tick = 1'b0;
   always @(negedge clk) begin
      ph   = (ph + 1) % 4;
      tick = (ph == 0);
   end

   // ---------------- behavioural reference model ----------------
   // 0 off,1 unconn,2 attached,3 bus reset,4 chirpJ,5 chirpK,6 pend,7 hs,8 fixwait,9 fixrun
   int m_st, m_cnt, m_low;

   always @(posedge clk or negedge rst_n) begin : mdl
      int  n;
      bit  sh, rng;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_low = 0;
      end else begin
         sh  = (m_low >= RSTMIN);
         rng = (m_cnt >= MINC) && (m_cnt <= MAXC);
         if (!pin_n) begin
            if (tick && m_low < RSTMIN) m_low = m_low + 1;
         end else m_low = 0;
         n = m_st;
         if (sh) n = 0;
         else if (m_st == 0 || hold) n = 1;
         else if (m_st >= 2 && m_st <= 7 && !pu) n = 1;
         else begin
            case (m_st)
               1: if (pu) n = 2; else if (fix) n = 8;
               2: if (line == 2'b00 && tick && m_cnt == SE0R - 1) n = 3;
               3: if (line == 2'b01) n = 4; else if (line == 2'b10) n = 2;
               4: if (line != 2'b01) n = (line == 2'b10 && rng) ? 5 : 2;
                  else if (tick && m_cnt == MAXC) n = 2;
               5: if (line != 2'b10) n = rng ? 6 : 2;
                  else if (tick && m_cnt == MAXC) n = 2;
               6: if (sq) n = 7; else if (line == 2'b01 || line == 2'b10) n = 2;
               8: if (!fix) n = 1; else if (tp) n = 9;
               9: if (!fix) n = 1;
               default: n = m_st;
            endcase
         end
         if (n != m_st || (m_st == 2 && line != 2'b00)) m_cnt = 0;
         else if (tick && m_cnt < MAXC) m_cnt = m_cnt + 1;
         m_st = n;
      end
   end

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(conn, (m_st >= 2 && m_st <= 7) || m_st == 9, cur_req, "model conn_det");
         chk(hs,   (m_st == 7 || m_st == 9), cur_req, "model hs_active");
         chk(comp, hs, "R9", "comp_en vs hs_active");
      end
   end

   task automatic settle(input int k);
      repeat (k) @(negedge clk);
   endtask

   // hold a line state for n counted ticks (entry edge not counted)
   task automatic drive_for(input logic [1:0] l, input int n);
      int k;
      @(negedge clk);
      line = l;
      @(posedge clk);
      k = 0;
      while (k < n) begin
         @(posedge clk);
         if (tick) k++;
      end
   endtask

   task automatic handshake(input int jn, input int kn);
      drive_for(2'b00, SE0R + 2);
      drive_for(2'b01, jn);
      drive_for(2'b10, kn);
      @(negedge clk);
      line = 2'b00;
      sq   = 1'b1;
      settle(3);
   endtask

   task automatic back_to_idle_line;
      @(negedge clk);
      sq   = 1'b0;
      line = 2'b01;
      settle(2);
   endtask

   task automatic report;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nbad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         report();
      end
   end

   initial begin
      rst_n = 1'b0; pin_n = 1'b1; hold = 1'b0; pu = 1'b0; sq = 1'b0;
      fix = 1'b0; tp = 1'b0; line = 2'b01;
      settle(4);
      chk(conn, 1'b0, "R1", "reset conn_det");
      chk(hs,   1'b0, "R1", "reset hs_active");
      rst_n = 1'b1;
      settle(3);

      // R2: low/full-speed attach
      cur_req = "R2";
      pu = 1'b1;
      settle(1);
      chk(conn, 1'b1, "R1", "conn_det one cycle after pull-up");
      settle(10);
      chk(conn, 1'b1, "R2", "LS/FS attach conn_det");
      chk(hs,   1'b0, "R2", "LS/FS attach hs_active");
      chk(comp, 1'b0, "R2", "LS/FS attach comp_en");

      // R1: disconnect
      cur_req = "R1";
      pu = 1'b0;
      settle(1);
      chk(conn, 1'b0, "R1", "disconnect conn_det");
      pu = 1'b1;
      settle(2);

      // R4: good handshake at the inclusive limits
      cur_req = "R4";
      handshake(MINC, MAXC);
      chk(hs,   1'b1, "R4", "hs_active after J=18 K=128 and squelch");
      chk(comp, 1'b1, "R9", "comp_en in high speed");
      chk(conn, 1'b1, "R4", "conn_det in high speed");
      pu = 1'b0;
      settle(1);
      chk(hs,   1'b0, "R1", "disconnect from high speed hs_active");
      chk(conn, 1'b0, "R1", "disconnect from high speed conn_det");
      sq = 1'b0; line = 2'b01; pu = 1'b1;
      settle(2);

      // R5: short J chirp
      cur_req = "R5";
      handshake(MINC - 1, 20);
      chk(hs,   1'b0, "R5", "J chirp of 17 rejected");
      chk(conn, 1'b1, "R5", "conn_det kept after abort");
      back_to_idle_line();
      // back at wait-for-reset: a proper handshake now succeeds
      handshake(MAXC, MINC);
      chk(hs, 1'b1, "R4", "retry after abort J=128 K=18");
      pu = 1'b0; settle(1); sq = 1'b0; line = 2'b01; pu = 1'b1; settle(2);

      // R5: K chirp of 129 ticks
      handshake(20, MAXC + 1);
      chk(hs, 1'b0, "R5", "K chirp of 129 rejected");
      back_to_idle_line();

      // R5: extra J chirp before squelch
      drive_for(2'b00, SE0R + 2);
      drive_for(2'b01, 20);
      drive_for(2'b10, 20);
      drive_for(2'b01, 2);
      @(negedge clk); line = 2'b00; sq = 1'b1;
      settle(3);
      chk(hs, 1'b0, "R5", "extra J chirp aborts handshake");
      back_to_idle_line();

      // R5: K chirp first after reset
      drive_for(2'b00, SE0R + 2);
      drive_for(2'b10, 20);
      drive_for(2'b01, 20);
      drive_for(2'b10, 20);
      @(negedge clk); line = 2'b00; sq = 1'b1;
      settle(3);
      chk(hs, 1'b0, "R5", "K chirp first aborts handshake");
      back_to_idle_line();

      // R3: SE0 too short to count as bus reset
      cur_req = "R3";
      drive_for(2'b00, SE0R - 2);
      drive_for(2'b01, 20);
      drive_for(2'b10, 20);
      @(negedge clk); line = 2'b00; sq = 1'b1;
      settle(3);
      chk(hs,   1'b0, "R3", "chirps without bus reset ignored");
      chk(conn, 1'b1, "R3", "still attached");
      back_to_idle_line();

      // R6: compliance fixture path
      cur_req = "R6";
      pu = 1'b0;
      settle(2);
      tp = 1'b1;
      settle(2);
      chk(hs, 1'b0, "R6", "test packet without fixture ignored");
      tp = 1'b0;
      fix = 1'b1;
      settle(3);
      chk(conn, 1'b0, "R6", "fixture alone no conn_det");
      chk(hs,   1'b0, "R6", "fixture alone no hs_active");
      tp = 1'b1;
      settle(1);
      tp = 1'b0;
      settle(1);
      chk(hs,   1'b1, "R6", "fixture + test packet hs_active");
      chk(conn, 1'b1, "R6", "fixture + test packet conn_det");
      fix = 1'b0;
      settle(1);
      chk(hs, 1'b0, "R6", "fixture removed");

      // R7: enable pin filter and shutdown
      cur_req = "R7";
      pu = 1'b1; line = 2'b01;
      settle(2);
      handshake(30, 30);
      chk(hs, 1'b1, "R4", "high speed before shutdown test");
      pin_n = 1'b0;
      settle(4 * (RSTMIN - 10));
      pin_n = 1'b1;
      settle(3);
      chk(hs, 1'b1, "R7", "short low pulse ignored");
      pin_n = 1'b0;
      settle(4 * (RSTMIN + 5));
      chk(conn, 1'b0, "R7", "shutdown conn_det");
      chk(hs,   1'b0, "R7", "shutdown hs_active");
      chk(comp, 1'b0, "R7", "shutdown comp_en");
      pin_n = 1'b1;
      settle(3);
      chk(conn, 1'b1, "R7", "restart after release");
      chk(hs,   1'b0, "R7", "no high speed after restart");

      // R8: configuration hold
      cur_req = "R8";
      sq = 1'b0;
      hold = 1'b1;
      settle(2);
      chk(conn, 1'b0, "R8", "hold forces idle");
      settle(6);
      chk(conn, 1'b0, "R8", "hold keeps idle");
      hold = 1'b0;
      settle(3);
      chk(conn, 1'b1, "R8", "detection resumes after hold");

      settle(4);
      report();
   end

endmodule